// File: doc/BRIEF.md
# I2C Serial EEPROM Target with Write Protection

This block is an I2C target that behaves like a 256-byte, byte-wide serial EEPROM. It oversamples the bus lines with its own system clock, finds START and STOP conditions, and answers when the device-select byte carries the memory preamble and the three strap bits match `strap_i`. A master can set the byte pointer, write one byte or a page of up to 16 bytes, read at the current pointer, or set the pointer and then read any number of bytes in a row.

Write data first goes into a 16-entry page buffer. Only a STOP moves it into the array, and that starts a busy window of `WCYC` system clocks during which no device-select byte is acknowledged. Two mechanisms block writes. While `wp_i` is high, every write to the array is blocked. A second device-select preamble, used for a write followed by a byte address, sets a sticky flag that blocks writes to the lower half of the array. Only reset clears that flag.

SDA is open-drain. The block never drives a high level. It asserts `sda_oe` to pull the line low, and the bus value (the wired AND of all drivers) comes back in on `sda_i`.

Top module: `eeprom_i2c_tgt`

## Requirements
- R1: After reset `sda_oe` is 0, every array byte reads 0xFF, and the byte pointer is 0x00.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bytes clocked before any START get no acknowledge, and `sda_oe` stays 0 while the block is idle.
- R3: The device-select byte is taken MSB first as {preamble[3:0], strap[2:0], rw}. If the strap field differs from `strap_i`, or the preamble is neither 4'b1010 nor 4'b0110, there is no acknowledge, and the block stays silent until the next START.
- R4: In a write command the block pulls SDA low in the 9th SCL pulse after the matching device-select byte, after the byte address, and after every data byte.
- R5: Write data reaches the array only when a STOP ends the write. A write that ends with a repeated START stores nothing.
- R6: Inside a write, only the low 4 pointer bits advance, wrapping within the 16-byte page. When more than 16 bytes are sent, the last byte sent to each offset is the one stored.
- R7: In a read the block sends 8 bits MSB first and releases SDA in the 9th pulse. If the master answers with ACK (SDA low), the next byte comes from the pointer plus one, with 0xFF wrapping to 0x00. If the master answers with NoACK, the block drives nothing until the next START or STOP.
- R8: A read select with no byte address in front of it starts at the current pointer. A write select plus byte address, followed by a repeated START and a read select, reads from that address.
- R9: While `wp_i` is high at the STOP, no array byte changes. The write bytes are still acknowledged.
- R10: A write with preamble 4'b0110, a matching strap field and an acknowledged byte address, ended by STOP, sets the lower-half protect flag. From then on, addresses 0x00 to 0x7F do not change and 0x80 to 0xFF stay writable. A read select with preamble 4'b0110 gets no acknowledge.
- R11: After a STOP that commits data, no device-select byte is acknowledged for `WCYC` system clocks.
- R12: `sda_oe` goes from 0 to 1 only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_i | input | 3 | Device address straps compared with select bits 3..1 |
| wp_i | input | 1 | Hardware protect; high blocks all array writes |

## Verification
Each bus input passes two synchronizer flops and one edge register before the block acts on it. Acknowledges and read bits therefore appear about three system clocks after the SCL falling edge that precedes them. The bench holds every SCL phase for eight clocks and samples SDA in the middle of the high phase, so it always sees the settled value.

Array contents can only be seen after the STOP plus the `WCYC` busy window. The bench waits longer than that window before it reads anything back. The one exception is the busy check itself, which issues a device select straight after the STOP, well inside the window.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam logic [3:0] PRE_MEM = 4'b1010;
    localparam logic [3:0] PRE_SWP = 4'b0110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_WAIT
    } state_e;

    typedef struct packed {
        logic [3:0] pre;
        logic [2:0] strap;
        logic       rd;
    } devsel_t;

    function automatic logic sel_hit(devsel_t d, logic [2:0] strap, logic busy);
        logic pre_ok;
        pre_ok = (d.pre == PRE_MEM) || (d.pre == PRE_SWP && !d.rd);
        return pre_ok && (d.strap == strap) && !busy;
    endfunction

endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_m, sda_m;
    logic       scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_m <= 2'b11;
            sda_m <= 2'b11;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_m <= {scl_m[0], scl_i};
            sda_m <= {sda_m[0], sda_i};
            scl_q <= scl_m[1];
            sda_q <= sda_m[1];
        end
    end

    assign scl_s     = scl_m[1];
    assign sda_s     = sda_m[1];
    assign scl_rise  = scl_s && !scl_q;
    assign scl_fall  = !scl_s && scl_q;
    assign start_det = scl_s && scl_q && sda_q && !sda_s;
    assign stop_det  = scl_s && scl_q && !sda_q && sda_s;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int PAGE_N = 1 << PAGE_W,
    localparam int PG_W   = ADDR_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              page_ld,
    input  logic [PG_W-1:0]   page_in,
    input  logic              buf_we,
    input  logic [PAGE_W-1:0] buf_off,
    input  logic [7:0]        buf_din,
    input  logic              commit,
    input  logic              wp,
    input  logic              swp,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [PAGE_N-1:0] arr_we,
    output logic [PG_W-1:0]   arr_page
);
    logic [7:0]        mem  [DEPTH];
    logic [7:0]        pbuf [PAGE_N];
    logic [PAGE_N-1:0] vld;
    logic              allow;

    // lower half is the set of pages whose top page bit is 0
    assign allow   = commit && !wp && !(swp && !arr_page[PG_W-1]);
    assign arr_we  = allow ? vld : '0;
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld      <= '0;
            arr_page <= '0;
        end else begin
            if (page_ld) begin
                vld      <= '0;
                arr_page <= page_in;
            end else if (buf_we) begin
                vld[buf_off] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_off] <= buf_din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= 8'hFF;
        end else begin
            for (int i = 0; i < PAGE_N; i++)
                if (arr_we[i]) mem[{arr_page, PAGE_W'(i)}] <= pbuf[i];
        end
    end
endmodule

// File: rtl/eeprom_i2c_tgt.sv
module eeprom_i2c_tgt #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4,
    parameter int WCYC   = 500,
    localparam int PAGE_N = 1 << PAGE_W,
    localparam int PG_W   = ADDR_W - PAGE_W,
    localparam int BSY_W  = $clog2(WCYC + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);
    import eep_pkg::*;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    eep_bus_sync u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    state_e            st;
    logic [3:0]        cnt;
    logic [7:0]        sh, tx;
    logic [ADDR_W-1:0] ptr;
    logic              drv, rw, swp_cmd, addr_done, pend, swp_flag, mack;
    logic [BSY_W-1:0]  bsy_cnt;
    logic              busy, fall8, page_ld, buf_we, commit;
    logic [7:0]        rd_data;
    logic [PAGE_N-1:0] arr_we;
    logic [PG_W-1:0]   arr_page;
    devsel_t           dsel;

    assign busy   = bsy_cnt != '0;
    assign fall8  = scl_fall && cnt == 4'd8;
    assign dsel   = devsel_t'(sh);
    assign page_ld = fall8 && st == ST_ADDR && !swp_cmd;
    assign buf_we  = fall8 && st == ST_WDATA && !swp_cmd;
    assign commit  = stop_det && pend && !swp_cmd;
    assign sda_oe  = drv;

    eep_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk(clk), .rst(rst),
        .page_ld(page_ld), .page_in(sh[7 -: PG_W]),
        .buf_we(buf_we), .buf_off(ptr[PAGE_W-1:0]), .buf_din(sh),
        .commit(commit), .wp(wp_i), .swp(swp_flag),
        .rd_addr(ptr), .rd_data(rd_data),
        .arr_we(arr_we), .arr_page(arr_page)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bsy_cnt <= '0;
        end else if (commit) begin
            bsy_cnt <= BSY_W'(WCYC);
        end else if (busy) begin
            bsy_cnt <= bsy_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0; ptr <= '0;
            drv <= 1'b0; rw <= 1'b0; swp_cmd <= 1'b0; addr_done <= 1'b0;
            pend <= 1'b0; swp_flag <= 1'b0; mack <= 1'b0;
        end else if (start_det) begin
            st <= ST_DEV; cnt <= '0; drv <= 1'b0;
            pend <= 1'b0; swp_cmd <= 1'b0; addr_done <= 1'b0;
        end else if (stop_det) begin
            if (swp_cmd && addr_done) swp_flag <= 1'b1;
            st <= ST_IDLE; drv <= 1'b0; pend <= 1'b0;
        end else begin
            case (st)
                ST_DEV, ST_ADDR, ST_WDATA: begin
                    if (scl_rise && cnt < 4'd8) begin
                        sh  <= {sh[6:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end else if (fall8) begin
                        cnt <= 4'd9;
                        drv <= 1'b1;
                        if (st == ST_DEV) begin
                            rw      <= dsel.rd;
                            swp_cmd <= dsel.pre == PRE_SWP;
                            if (!sel_hit(dsel, strap_i, busy)) begin
                                st  <= ST_IDLE;
                                drv <= 1'b0;
                            end
                        end else if (st == ST_ADDR) begin
                            if (swp_cmd) addr_done <= 1'b1;
                            else         ptr <= sh;
                        end else if (!swp_cmd) begin
                            ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
                            pend <= 1'b1;
                        end
                    end else if (scl_fall && cnt == 4'd9) begin
                        cnt <= '0;
                        drv <= 1'b0;
                        if (st == ST_DEV && rw) begin
                            st  <= ST_RDATA;
                            tx  <= rd_data;
                            drv <= ~rd_data[7];
                        end else if (st == ST_DEV) begin
                            st <= ST_ADDR;
                        end else begin
                            st <= ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise && cnt < 4'd8) begin
                        cnt <= cnt + 1'b1;
                    end else if (scl_rise && cnt == 4'd8) begin
                        mack <= ~sda_s;
                        cnt  <= 4'd9;
                    end else if (scl_fall && cnt != 4'd0 && cnt < 4'd8) begin
                        tx  <= {tx[6:0], 1'b0};
                        drv <= ~tx[6];
                    end else if (fall8) begin
                        drv <= 1'b0;
                        ptr <= ptr + 1'b1;
                    end else if (scl_fall && cnt == 4'd9) begin
                        cnt <= '0;
                        if (mack) begin
                            tx  <= rd_data;
                            drv <= ~rd_data[7];
                        end else begin
                            st <= ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/eep_chk.sv
module eep_chk #(
    parameter int PAGE_N = 16,
    parameter int PG_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              sda_oe,
    input logic              scl_s,
    input logic              wp_i,
    input logic              busy,
    input logic              swp_flag,
    input eep_pkg::state_e   st,
    input logic [PAGE_N-1:0] arr_we,
    input logic [PG_W-1:0]   arr_page
);
    import eep_pkg::*;

    AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        st == ST_IDLE |-> !sda_oe); // R2

    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (busy && st == ST_DEV) |-> !sda_oe); // R11

    AST_COMMIT_THEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        arr_we != '0 |=> busy); // R11

    AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        arr_we != '0 |-> !wp_i); // R9

    AST_SWP_UPPER_ONLY: assert property (@(posedge clk) disable iff (rst)
        (arr_we != '0 && swp_flag) |-> arr_page[PG_W-1]); // R10
endmodule

bind eeprom_i2c_tgt eep_chk #(.PAGE_N(PAGE_N), .PG_W(PG_W)) u_chk (
    .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_s(scl_s), .wp_i(wp_i),
    .busy(busy), .swp_flag(swp_flag), .st(st), .arr_we(arr_we), .arr_page(arr_page)
);

// File: tb/test_eeprom_i2c_tgt.sv
module test_eeprom_i2c_tgt;
    localparam int WCYC = 500;
    localparam int Q    = 8;

    logic       clk = 1'b0, rst = 1'b1;
    logic       scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
    logic [2:0] strap = 3'b101;
    logic       sda_oe, sda_line;

    assign sda_line = sda_m & ~sda_oe;
    always #5 clk = ~clk;

    eeprom_i2c_tgt #(.WCYC(WCYC)) i_eeprom_i2c_tgt (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(strap), .wp_i(wp)
    );

    int n_run = 0, n_fail = 0, r12_bad = 0;
    bit done = 0, swp_m = 0;
    logic [7:0] ref_mem [256];
    logic [7:0] wdat [32];
    logic [7:0] rdat [32];
    logic prev_oe = 1'b0;

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hw(int n);
        repeat (n) @(negedge clk);
    endtask

    // R12 monitor: drive may only start while SCL is low
    always @(negedge clk) begin
        if (!rst && sda_oe && !prev_oe && scl_m) r12_bad++;
        prev_oe <= sda_oe;
    end

    task automatic bus_start();
        sda_m = 1'b1; hw(2); scl_m = 1'b1; hw(Q); sda_m = 1'b0; hw(Q); scl_m = 1'b0; hw(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hw(Q); scl_m = 1'b1; hw(Q); sda_m = 1'b1; hw(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hw(Q); scl_m = 1'b1; hw(Q); scl_m = 1'b0; hw(2);
        end
        sda_m = 1'b1; hw(Q); scl_m = 1'b1; hw(Q/2);
        ack = ~sda_line;
        hw(Q/2); scl_m = 1'b0; hw(2);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw(Q); scl_m = 1'b1; hw(Q/2); b[i] = sda_line; hw(Q/2); scl_m = 1'b0; hw(2);
        end
        sda_m = ~mack; hw(Q); scl_m = 1'b1; hw(Q); scl_m = 1'b0; hw(2); sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dsel(bit swp, bit rd);
        return {swp ? 4'b0110 : 4'b1010, strap, rd};
    endfunction

    function automatic void model_write(logic [7:0] addr, int n);
        logic [7:0] pb [16];
        bit v [16];
        for (int k = 0; k < 16; k++) v[k] = 0;
        for (int k = 0; k < n; k++) begin
            pb[(addr[3:0] + k) % 16] = wdat[k];
            v[(addr[3:0] + k) % 16]  = 1;
        end
        for (int k = 0; k < 16; k++) begin
            logic [7:0] a;
            a = {addr[7:4], 4'(k)};
            if (v[k] && !wp && !(swp_m && !a[7])) ref_mem[a] = pb[k];
        end
    endfunction

    task automatic mem_write(input logic [7:0] addr, input int n, output bit all_ack);
        bit a;
        all_ack = 1;
        bus_start();
        send_byte(dsel(0, 0), a); all_ack &= a;
        send_byte(addr, a); all_ack &= a;
        for (int k = 0; k < n; k++) begin
            send_byte(wdat[k], a); all_ack &= a;
        end
        bus_stop();
    endtask

    task automatic mem_read(input logic [7:0] addr, input int n, output bit all_ack);
        bit a;
        all_ack = 1;
        bus_start();
        send_byte(dsel(0, 0), a); all_ack &= a;
        send_byte(addr, a); all_ack &= a;
        bus_start();
        send_byte(dsel(0, 1), a); all_ack &= a;
        for (int k = 0; k < n; k++) recv_byte(k != n - 1, rdat[k]);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        bit ok, a;
        logic [7:0] b;
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
        hw(5); rst = 1'b0; hw(5);

        chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);

        // R2: no START first, byte must not be acknowledged
        send_byte(dsel(0, 0), a);
        chk(a == 0, "R2 no ack without START", a, 0);
        bus_stop();

        // R1/R8: current read right after reset begins at pointer 0
        bus_start(); send_byte(dsel(0, 1), a);
        recv_byte(0, b); bus_stop();
        chk(a == 1, "R8 current read select ack", a, 1);
        chk(b == 8'hFF, "R1 erased array at pointer 0", b, 8'hFF);

        // R3: wrong strap, then silence until START
        bus_start(); send_byte({4'b1010, strap ^ 3'b001, 1'b0}, a);
        chk(a == 0, "R3 strap mismatch", a, 0);
        send_byte(8'h00, a);
        chk(a == 0, "R3 silent after mismatch", a, 0);
        bus_stop();
        bus_start(); send_byte({4'b1110, strap, 1'b0}, a);
        chk(a == 0, "R3 unknown preamble", a, 0);
        bus_stop();

        // R4/R11: three byte write, then immediate select while busy
        wdat[0] = 8'h12; wdat[1] = 8'h34; wdat[2] = 8'h56;
        mem_write(8'h10, 3, ok); model_write(8'h10, 3);
        chk(ok, "R4 write acks", ok, 1);
        bus_start(); send_byte(dsel(0, 0), a); bus_stop();
        chk(a == 0, "R11 no ack while busy", a, 0);
        hw(WCYC + 20);
        mem_read(8'h10, 3, ok);
        chk(ok, "R8 random read acks", ok, 1);
        for (int k = 0; k < 3; k++)
            chk(rdat[k] == ref_mem[8'h10 + k], "R5 R7 sequential readback", rdat[k], ref_mem[8'h10 + k]);

        // R5: write ended by repeated START stores nothing
        bus_start(); send_byte(dsel(0, 0), a); send_byte(8'h20, a); send_byte(8'h55, a);
        bus_start(); send_byte(dsel(0, 1), a); recv_byte(0, b); bus_stop();
        chk(b == ref_mem[8'h21], "R8 current read after pointer advance", b, ref_mem[8'h21]);
        mem_read(8'h20, 1, ok);
        chk(ok, "R11 no busy after aborted write", ok, 1);
        chk(rdat[0] == 8'hFF, "R5 repeated START discards data", rdat[0], 8'hFF);

        // R6: 18 bytes from 0x3E roll inside the page
        for (int k = 0; k < 18; k++) wdat[k] = 8'h80 + 8'(k);
        mem_write(8'h3E, 18, ok); model_write(8'h3E, 18); hw(WCYC + 20);
        mem_read(8'h30, 16, ok);
        for (int k = 0; k < 16; k++)
            chk(rdat[k] == ref_mem[8'h30 + k], "R6 page rollover", rdat[k], ref_mem[8'h30 + k]);

        // R7: read wraps 0xFF to 0x00
        wdat[0] = 8'hA5; mem_write(8'hFF, 1, ok); model_write(8'hFF, 1); hw(WCYC + 20);
        mem_read(8'hFE, 3, ok);
        chk(rdat[1] == 8'hA5, "R7 byte at 0xFF", rdat[1], 8'hA5);
        chk(rdat[2] == ref_mem[0], "R7 wrap to 0x00", rdat[2], ref_mem[0]);

        // R7: after NoACK, nothing is driven
        wdat[0] = 8'h00; mem_write(8'h44, 1, ok); model_write(8'h44, 1); hw(WCYC + 20);
        bus_start(); send_byte(dsel(0, 0), a); send_byte(8'h44, a);
        bus_start(); send_byte(dsel(0, 1), a);
        recv_byte(0, b);
        chk(b == 8'h00, "R7 zero byte read", b, 0);
        recv_byte(0, b);
        chk(b == 8'hFF, "R7 released after NoACK", b, 8'hFF);
        bus_stop();

        // R9: hardware protect
        wp = 1'b1; wdat[0] = 8'h3C;
        mem_write(8'h50, 1, ok); model_write(8'h50, 1);
        chk(ok, "R9 acks while protected", ok, 1);
        wp = 1'b0; hw(WCYC + 20);
        mem_read(8'h50, 1, ok);
        chk(rdat[0] == 8'hFF, "R9 protected byte unchanged", rdat[0], 8'hFF);

        // R10: software protect of the lower half
        bus_start(); send_byte(dsel(1, 1), a); bus_stop();
        chk(a == 0, "R10 protect read select not acked", a, 0);
        bus_start(); send_byte(dsel(1, 0), a); send_byte(8'h00, ok); bus_stop();
        chk(a && ok, "R10 protect command acked", a && ok, 1);
        swp_m = 1;
        wdat[0] = 8'h77; mem_write(8'h05, 1, ok); model_write(8'h05, 1); hw(WCYC + 20);
        wdat[0] = 8'h66; mem_write(8'h85, 1, ok); model_write(8'h85, 1); hw(WCYC + 20);
        mem_read(8'h05, 1, ok);
        chk(rdat[0] == 8'hFF, "R10 lower half blocked", rdat[0], 8'hFF);
        mem_read(8'h85, 1, ok);
        chk(rdat[0] == 8'h66, "R10 upper half writable", rdat[0], 8'h66);

        // random mix, R5 R6 R9 R10
        for (int it = 0; it < 10; it++) begin
            logic [7:0] ad;
            int n;
            ad = 8'($urandom % 256);
            n  = 1 + int'($urandom % 20);
            for (int k = 0; k < n; k++) wdat[k] = 8'($urandom);
            wp = ($urandom % 4) == 0;
            mem_write(ad, n, ok); model_write(ad, n);
            wp = 1'b0;
            chk(ok, "R4 random write acks", ok, 1);
            hw(WCYC + 20);
            mem_read({ad[7:4], 4'h0}, 16, ok);
            for (int k = 0; k < 16; k++)
                chk(rdat[k] == ref_mem[{ad[7:4], 4'(k)}], "R6 R9 R10 random page",
                    rdat[k], ref_mem[{ad[7:4], 4'(k)}]);
        end

        chk(r12_bad == 0, "R12 drive starts with SCL low", r12_bad, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule